// File: doc/BRIEF.md
# Reloadable Down-Counter Timer Channel

This block is a single timer channel. A 32-bit counter counts down and reloads itself from a 32-bit constant register when it runs out. The parent unit sets the channel running or stopped with a `start` input. While it runs, a prescaler divides the block clock by a selectable power of four, and each divided tick lowers the counter by one.

When the counter is at zero and a tick arrives, the counter takes the reload constant and sets a sticky underflow flag. The flag, gated by an enable bit, drives the interrupt output. Software reaches four 32-bit words through a word-indexed register port: the reload constant, the live counter, the control word, and a plain storage word for capture. Index 0 to 3 matches byte offsets 0x0, 0x4, 0x8 and 0xC.

The control word holds these fields:

- bits 2:0 select the prescaler.
- bits 4:3 select the clock source.
- bit 5 enables the interrupt.
- bits 7:6 set the capture mode.
- bit 8 is the underflow flag.
- bit 9 is the capture flag.

A control write that the block cannot honour is refused. The refusal is reported with a one-cycle error pulse.

Top module: `reload_timer_chan`

## Requirements
- R1: After reset, word 0 (reload) and word 1 (counter) read 0xFFFFFFFF, word 2 (control) reads 0, and `err` and `irq` are low.
- R2: A write to word 0 or word 1 is visible on the next read. Word 1 always reads the live count. A counter write wins over a tick in the same cycle.
- R3: While `start` is high, prescale code c (0 to 4, control bits 2:0) lowers the counter once every 4^(c+1) clock cycles. While `start` is low, the counter and the prescaler phase hold.
- R4: A tick with the counter at 0 loads the reload constant and sets the underflow flag (control bit 8).
- R5: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves the flag as it was.
- R6: `irq` equals the underflow flag ANDed with the interrupt enable (control bit 5).
- R7: Some control writes are invalid. For any of them, `err` is high for exactly the cycle after the write, and the control word is left unchanged. A control write is invalid if any of these holds:
  - any bit in 31:10 is set;
  - the prescale code is 5, or is 6 or 7 without the external clock option;
  - the clock source field (bits 4:3) is nonzero without the external clock option;
  - the capture mode (bits 7:6) is 1, or is nonzero without the capture option;
  - bit 9 is set without the capture option.
- R8: An accepted control write restarts the prescaler phase from zero. No tick occurs in the write cycle, so a full new period follows.
- R9: With the capture option, word 3 is a read/write storage word that resets to 0. Without it, any access to word 3 pulses `err` in the next cycle.
- R10: Control bit 9 (capture flag) always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run enable from the parent unit |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | Word index (0 reload, 1 counter, 2 control, 3 capture) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `reg_sel` |
| err | output | 1 | One-cycle pulse after a refused access |
| irq | output | 1 | Underflow interrupt |

## Verification
The bench aims at four corner cases:

- Underflow at exactly zero, with small random reload values and start counts. A design that reloads one tick early or late, or wraps to all ones, would drift from the bench model over repeated reloads.
- Rewriting the control word in the middle of a prescaler period. If the phase is not cleared, the counter drops before a full new period has elapsed.
- Each class of illegal control value. A design that takes such a value would change the read-back or fail to raise the error pulse.
- Writing 1 to the flag bit while the flag is set, then 0. A design that stores the written bit directly would set the flag wrongly or fail to clear it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned PSC_MAX_CODE = 4;
  localparam int unsigned PSC_W        = 2 * PSC_MAX_CODE + 2;
  localparam int unsigned CTRL_W       = 8;
  localparam int unsigned FLAG_BIT     = 8;
  localparam int unsigned CAPF_BIT     = 9;
  localparam int unsigned RSV_LO       = 10;

  localparam logic [1:0] W_RELOAD = 2'd0;
  localparam logic [1:0] W_COUNT  = 2'd1;
  localparam logic [1:0] W_CTRL   = 2'd2;
  localparam logic [1:0] W_CAPT   = 2'd3;

  typedef struct packed {
    logic [1:0] cap_ctl;
    logic       ie;
    logic [1:0] clk_src;
    logic [2:0] psc;
  } tmr_ctrl_t;

  function automatic logic [PSC_W-1:0] psc_last(input logic [2:0] code);
    logic [PSC_W-1:0] r;
    r = '0;
    for (int i = 0; i <= int'(PSC_MAX_CODE); i++) begin
      if (code == 3'(i)) r = PSC_W'((1 << (2 * i + 2)) - 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PSC_W-1:0] phase_q, phase_d;
  logic             code_ok, at_last, adv_en;

  assign code_ok = (code <= 3'(PSC_MAX_CODE));
  assign at_last = (phase_q == psc_last(code));
  assign adv_en  = run && code_ok;
  assign tick    = adv_en && !clear && at_last;

  always_comb begin
    phase_d = phase_q;
    if (clear)        phase_d = '0;
    else if (adv_en)  phase_d = at_last ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_cnt,
  input  logic              load_reload,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              underflow
);
  logic [DATA_W-1:0] cnt_d, reload_d;
  logic              at_zero;

  assign at_zero   = (cnt_q == '0);
  assign underflow = tick && at_zero && !load_cnt;

  always_comb begin
    cnt_d = cnt_q;
    if (load_cnt)   cnt_d = wdata;
    else if (tick)  cnt_d = at_zero ? reload_q : cnt_q - 1'b1;
  end

  always_comb begin
    reload_d = reload_q;
    if (load_reload) reload_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '1;
      reload_q <= '1;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter bit          EXTCLK_EN  = 1'b0,
  parameter bit          CAPTURE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_flag,
  output tmr_ctrl_t         ctrl_q,
  output logic              flag_q,
  output logic              accept,
  output logic              reject
);
  tmr_ctrl_t  w_ctrl, ctrl_d;
  logic       flag_d;
  logic       psc_ok, src_ok, cap_ok, capf_ok, rsv_ok, legal;

  assign w_ctrl  = tmr_ctrl_t'(wdata[CTRL_W-1:0]);
  assign psc_ok  = (w_ctrl.psc <= 3'(PSC_MAX_CODE)) ||
                   (EXTCLK_EN && (w_ctrl.psc >= 3'd6));
  assign src_ok  = (w_ctrl.clk_src == 2'd0) || EXTCLK_EN;
  assign cap_ok  = (w_ctrl.cap_ctl == 2'd0) || (CAPTURE_EN && w_ctrl.cap_ctl[1]);
  assign capf_ok = !wdata[CAPF_BIT] || CAPTURE_EN;
  assign rsv_ok  = (wdata[DATA_W-1:RSV_LO] == '0);
  assign legal   = psc_ok && src_ok && cap_ok && capf_ok && rsv_ok;

  assign accept  = wr_en && legal;
  assign reject  = wr_en && !legal;

  always_comb begin
    ctrl_d = ctrl_q;
    flag_d = flag_q;
    if (accept) begin
      ctrl_d = w_ctrl;
      if (!wdata[FLAG_BIT]) flag_d = 1'b0;
    end
    if (set_flag) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/reload_timer_chan.sv
module reload_timer_chan
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter bit          EXTCLK_EN  = 1'b0,
  parameter bit          CAPTURE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              irq
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              wr_reload, wr_count, wr_ctrl, wr_capt, hit_capt;
  logic              tick, underflow, accept, reject, flag_q;
  logic              err_d;
  tmr_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] cnt_q, reload_q, cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign wr_reload = sel && wr && (reg_sel == W_RELOAD);
  assign wr_count  = sel && wr && (reg_sel == W_COUNT);
  assign wr_ctrl   = sel && wr && (reg_sel == W_CTRL);
  assign hit_capt  = sel && (reg_sel == W_CAPT);
  assign wr_capt   = hit_capt && wr;

  tmr_prescaler u_psc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (start),
    .clear (accept),
    .code  (ctrl_q.psc),
    .tick  (tick)
  );

  tmr_down_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick        (tick),
    .load_cnt    (wr_count),
    .load_reload (wr_reload),
    .wdata       (wdata),
    .cnt_q       (cnt_q),
    .reload_q    (reload_q),
    .underflow   (underflow)
  );

  tmr_ctrl_reg #(
    .DATA_W     (DATA_W),
    .EXTCLK_EN  (EXTCLK_EN),
    .CAPTURE_EN (CAPTURE_EN)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_ctrl),
    .wdata    (wdata),
    .set_flag (underflow),
    .ctrl_q   (ctrl_q),
    .flag_q   (flag_q),
    .accept   (accept),
    .reject   (reject)
  );

  generate
    if (CAPTURE_EN) begin : g_capt
      logic [DATA_W-1:0] cap_d;
      always_comb begin
        cap_d = cap_q;
        if (wr_capt) cap_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) cap_q <= '0;
        else            cap_q <= cap_d;
      end
      assign err_d = reject;
    end else begin : g_nocapt
      assign cap_q = '0;
      assign err_d = reject || hit_capt || wr_capt;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err <= 1'b0;
    else            err <= err_d;
  end

  always_comb begin
    rdata = '0;
    unique case (reg_sel)
      W_RELOAD: rdata = reload_q;
      W_COUNT:  rdata = cnt_q;
      W_CTRL: begin
        rdata[CTRL_W-1:0] = ctrl_q;
        rdata[FLAG_BIT]   = flag_q;
        rdata[CAPF_BIT]   = 1'b0;
      end
      default:  rdata = cap_q;
    endcase
  end

  assign irq = flag_q && ctrl_q.ie;
endmodule

// File: rtl/tmr_chan_checker.sv
module tmr_chan_checker
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              sel,
  input logic              wr,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] wdata,
  input logic              tick,
  input logic              accept,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] reload_q,
  input logic              flag_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              err
);
  logic wcnt, wrel, wctl;
  assign wcnt = sel && wr && (reg_sel == W_COUNT);
  assign wrel = sel && wr && (reg_sel == W_RELOAD);
  assign wctl = sel && wr && (reg_sel == W_CTRL);

  assert_reload_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrel |=> (reload_q == $past(wdata)));

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wcnt) |=> $stable(cnt_q));

  assert_underflow_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt_q == '0) && !wcnt) |=> ((cnt_q == $past(reload_q)) && flag_q));

  assert_flag_clear_only_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wctl && !wdata[FLAG_BIT]));

  assert_refused_ctrl_unchanged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(ctrl_q));

  assert_phase_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tick);
endmodule

bind reload_timer_chan tmr_chan_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .start    (start),
  .sel      (sel),
  .wr       (wr),
  .reg_sel  (reg_sel),
  .wdata    (wdata),
  .tick     (tick),
  .accept   (accept),
  .cnt_q    (cnt_q),
  .reload_q (reload_q),
  .flag_q   (flag_q),
  .ctrl_q   (ctrl_q),
  .err      (err)
);

// File: tb/sim_reload_timer_chan.sv
`timescale 1ns/1ps
module sim_reload_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n, start, sel, sel1, wr;
  logic [1:0]  reg_sel;
  logic [31:0] wdata, rdata, rdata1;
  logic        err, irq, err1, irq1;
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  reload_timer_chan u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .wr(wr),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq));

  reload_timer_chan #(.CAPTURE_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(1'b0), .sel(sel1), .wr(wr),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata1), .err(err1), .irq(irq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; reg_sel = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic wreg1(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel1 = 1'b1; wr = 1'b1; reg_sel = a; wdata = d;
    @(negedge clk);
    sel1 = 1'b0; wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; reg_sel = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  function automatic logic [32:0] model(input int v, input int r, input int k);
    if (k <= v) return {1'b0, 32'(v - k)};
    return {1'b1, 32'(r - ((k - v - 1) % (r + 1)))};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d, c0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; sel = 1'b0; sel1 = 1'b0; wr = 1'b0;
    reg_sel = 2'd0; wdata = '0;
    step(5);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    rreg(2'd0, d); chk("R1 reload", d, 32'hFFFF_FFFF);
    rreg(2'd1, d); chk("R1 counter", d, 32'hFFFF_FFFF);
    rreg(2'd2, d); chk("R1 control", d, 32'h0);
    chk("R1 err", {31'b0, err}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 register writes
    wreg(2'd0, 32'h1234_5678); rreg(2'd0, d); chk("R2 reload", d, 32'h1234_5678);
    wreg(2'd1, 32'hCAFE_F00D); rreg(2'd1, d); chk("R2 counter", d, 32'hCAFE_F00D);

    // R3 stopped counter holds
    wreg(2'd1, 32'h100);
    step(40);
    rreg(2'd1, d); chk("R3 hold while stopped", d, 32'h100);

    // R4 underflow at zero
    wreg(2'd0, 32'd5); wreg(2'd1, 32'd0); wreg(2'd2, 32'h20);
    start = 1'b1; step(4); start = 1'b0;
    rreg(2'd1, d); chk("R4 reload on underflow", d, 32'd5);
    rreg(2'd2, d); chk("R4 flag set", d & 32'h100, 32'h100);
    chk("R6 irq with enable", {31'b0, irq}, 32'h1);

    // R5 / R6 flag handling
    wreg(2'd2, 32'h100);
    chk("R6 irq masked", {31'b0, irq}, 32'h0);
    rreg(2'd2, d); chk("R5 write one keeps flag", d, 32'h100);
    wreg(2'd2, 32'h120);
    chk("R6 irq reenabled", {31'b0, irq}, 32'h1);
    wreg(2'd2, 32'h020);
    rreg(2'd2, d); chk("R5 write zero clears", d, 32'h020);
    chk("R6 irq after clear", {31'b0, irq}, 32'h0);
    wreg(2'd2, 32'h100);
    rreg(2'd2, d); chk("R5 write one on clear flag", d, 32'h000);

    // R7 refused control writes
    wreg(2'd2, 32'h20);
    wreg(2'd2, 32'h420); chk("R7 reserved err", {31'b0, err}, 32'h1);
    rreg(2'd2, d); chk("R7 reserved unchanged", d, 32'h20);
    wreg(2'd2, 32'h25); chk("R7 code5 err", {31'b0, err}, 32'h1);
    wreg(2'd2, 32'h27); chk("R7 code7 err", {31'b0, err}, 32'h1);
    wreg(2'd2, 32'h28); chk("R7 clk src err", {31'b0, err}, 32'h1);
    wreg(2'd2, 32'h60); chk("R7 capture mode err", {31'b0, err}, 32'h1);
    rreg(2'd2, d); chk("R7 still unchanged", d, 32'h20);
    step(1); chk("R7 pulse one cycle", {31'b0, err}, 32'h0);
    wreg(2'd2, 32'hA3); chk("R7 valid no err", {31'b0, err}, 32'h0);
    rreg(2'd2, d); chk("R7 valid stored", d, 32'hA3);
    wreg1(2'd2, 32'h200); chk("R7 capf without option err", {31'b0, err1}, 32'h1);

    // R10 capture flag reads 0
    wreg(2'd2, 32'h200); chk("R10 no err", {31'b0, err}, 32'h0);
    rreg(2'd2, d); chk("R10 capture flag zero", d, 32'h0);

    // R9 capture storage
    rreg(2'd3, d); chk("R9 capture reset", d, 32'h0);
    wreg(2'd3, 32'hA5A5_1234); rreg(2'd3, d); chk("R9 capture rw", d, 32'hA5A5_1234);
    wreg1(2'd3, 32'h55); chk("R9 no-option write err", {31'b0, err1}, 32'h1);
    @(negedge clk); sel1 = 1'b1; wr = 1'b0; reg_sel = 2'd3;
    @(negedge clk); sel1 = 1'b0;
    chk("R9 no-option read err", {31'b0, err1}, 32'h1);

    // R8 control write restarts the prescaler phase (code 1: period 16)
    wreg(2'd1, 32'd100); wreg(2'd2, 32'h01);
    start = 1'b1; step(10);
    wreg(2'd2, 32'h01);
    rreg(2'd1, c0);
    step(15);
    rreg(2'd1, d); chk("R8 no early tick", d, c0);
    step(1);
    rreg(2'd1, d); chk("R8 tick after full period", d, c0 - 32'd1);
    start = 1'b0;

    // R3 R4 R6 random trials against the bench model
    for (int t = 0; t < 10; t++) begin
      int code, ratio, v, r, n, ie;
      logic [32:0] e;
      code  = $urandom % 3;
      ratio = 1 << (2 * code + 2);
      v     = $urandom % 8;
      r     = $urandom % 6;
      ie    = $urandom % 2;
      n     = $urandom % (ratio * 12);
      wreg(2'd0, 32'(r)); wreg(2'd1, 32'(v));
      wreg(2'd2, 32'(code) | (32'(ie) << 5));
      start = 1'b1; step(n); start = 1'b0;
      e = model(v, r, n / ratio);
      rreg(2'd1, d); chk("R3 random count", d, e[31:0]);
      rreg(2'd2, d); chk("R4 random flag", {31'b0, d[8]}, {31'b0, e[32]});
      chk("R6 random irq", {31'b0, irq}, {31'b0, e[32] & ie[0]});
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule